// File: doc/BRIEF.md
# Prioritised Interrupt Dispatch Unit

This unit gathers interrupt requests for a small 8-bit processor and decides, at each instruction boundary, whether the core must divert to a handler. Peripherals raise single-cycle pulses. Each pulse sets a sticky bit in a request register. Software can read and write that register on the processor bus, and it can also read and write an enable register that masks each source. A master enable flag gates every source at once. The instruction decoder drives the master enable through three strobes: disable, enable and return-from-handler.

When the master enable is on and at least one source is both requested and enabled, the unit asserts a dispatch command during a cycle flagged as an instruction boundary. The command carries the handler vector of the winning source, which is the lowest-numbered pending bit. On the clock edge that ends that cycle, the unit clears the winner's request bit and the master enable. The core pushes the return address itself.

There are five sources by default. Bit 0 is vertical blank, bit 1 is display status, bit 2 is the timer, bit 3 is serial and bit 4 is joypad. Their vectors start at 0x40 and are spaced 8 bytes apart.

Top module: `idu_dispatch`

## Requirements
- R1: After reset the request bits, the enable register and the master enable are all 0. Address 0xFF0F then reads 0xE0, 0xFFFF reads 0x00, and no dispatch is issued.
- R2: Address 0xFF0F reads the request bits in bits 4:0, with bits 7:5 read as 1. A bus write to 0xFF0F loads bits 4:0 from the write data.
- R3: Address 0xFFFF stores and reads back all 8 bits written. Only bits 4:0 act as per-source enables.
- R4: A one-cycle pulse on src_pulse[i] sets request bit i on the next edge. The bit stays set until a bus write or a dispatch clears it.
- R5: If a source pulse and a bus write to 0xFF0F fall in the same cycle, the pulsed bit ends up set. The other bits take the written value.
- R6: dispatch_valid is 1 only when insn_boundary is 1, the master enable is 1, and (request AND enable) is non-zero.
- R7: The lowest-numbered eligible bit wins. dispatch_vector equals 0x40 + 8 × index, giving 0x40, 0x48, 0x50, 0x58 and 0x60 for bits 0 to 4.
- R8: On the edge that ends a dispatch cycle, only the winner's request bit is cleared, and the master enable is cleared.
- R9: dec_ei and dec_reti set the master enable. dec_di clears it and overrides a set in the same cycle. A dispatch in the same cycle as dec_ei leaves the master enable clear.
- R10: Bus writes to any address other than 0xFF0F and 0xFFFF change neither register. Reads of any other address return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus address, used for both reads and writes |
| bus_wr | input | 1 | Bus write strobe |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| src_pulse | input | 5 | One-cycle request pulses, one per source |
| dec_di | input | 1 | Decoder strobe that clears the master enable |
| dec_ei | input | 1 | Decoder strobe that sets the master enable |
| dec_reti | input | 1 | Decoder strobe for return from handler, which sets the master enable |
| insn_boundary | input | 1 | High in the cycle in which a dispatch may be taken |
| dispatch_valid | output | 1 | Dispatch command for this cycle |
| dispatch_vector | output | 16 | Handler address of the winning source |
| ime | output | 1 | Current master enable |

## Verification
The bench builds the unit with its default parameters: five sources, 16-bit addresses, 8-bit data, and vectors based at 0x40 with a stride of 8. With five sources, every priority rank from 0x40 to 0x60 can be reached. They also leave three request bits unused, so the read-as-one upper field is visible, and they leave three enable bits that store but never gate. A vector table covers each winner and each masked case. Directed tests then cover collisions between a pulse and a write, collisions between a strobe and a dispatch, and the clearing of a single bit on dispatch.

// File: rtl/idu_pkg.sv
package idu_pkg;

   // Handler address of a source from its index.
   function automatic int unsigned vec_addr(input int unsigned base,
                                            input int unsigned stride,
                                            input int unsigned idx);
      return base + stride * idx;
   endfunction

endpackage

// File: rtl/idu_req_reg.sv
module idu_req_reg #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [N-1:0] wr_bits,
   input  logic [N-1:0] clr_bits,
   input  logic [N-1:0] set_bits,
   output logic [N-1:0] q
);
   // Per-bit precedence: pulse set, then dispatch clear, then bus write.
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)           q[i] <= 1'b0;
         else if (set_bits[i]) q[i] <= 1'b1;
         else if (clr_bits[i]) q[i] <= 1'b0;
         else if (wr_en)       q[i] <= wr_bits[i];
      end
   end
endmodule

// File: rtl/idu_prio_pick.sv
module idu_prio_pick #(
   parameter int N     = 5,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     cand,
   output logic [N-1:0]     grant,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   logic [N:0] blocked;
   assign blocked[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign grant[i]     = cand[i] & ~blocked[i];
      assign blocked[i+1] = blocked[i] | cand[i];
   end

   assign any = blocked[N];

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/idu_master_en.sv
module idu_master_en (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_req,
   input  logic take,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n)                q <= 1'b0;
      else if (take || clr_req)  q <= 1'b0;
      else if (set_req)          q <= 1'b1;
   end
endmodule

// File: rtl/idu_dispatch.sv
module idu_dispatch #(
   parameter int          NUM_SRC    = 5,
   parameter int          ADDR_W     = 16,
   parameter int          DATA_W     = 8,
   parameter logic [15:0] REQ_ADDR   = 16'hFF0F,
   parameter logic [15:0] EN_ADDR    = 16'hFFFF,
   parameter int          VEC_BASE   = 'h40,
   parameter int          VEC_STRIDE = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_SRC-1:0] src_pulse,
   input  logic               dec_di,
   input  logic               dec_ei,
   input  logic               dec_reti,
   input  logic               insn_boundary,
   output logic               dispatch_valid,
   output logic [ADDR_W-1:0]  dispatch_vector,
   output logic               ime
);
   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam logic [ADDR_W-1:0] REQ_A = ADDR_W'(REQ_ADDR);
   localparam logic [ADDR_W-1:0] EN_A  = ADDR_W'(EN_ADDR);

   initial begin
      assert (NUM_SRC >= 1 && NUM_SRC <= DATA_W)
         else $error("NUM_SRC must lie in 1..DATA_W");
      assert (ADDR_W >= 8 && ADDR_W <= 16)
         else $error("ADDR_W must lie in 8..16");
      assert (REQ_A != EN_A)
         else $error("register addresses collide");
      assert (64'(VEC_BASE) + 64'(VEC_STRIDE) * 64'(NUM_SRC - 1) < (64'(1) << ADDR_W))
         else $error("vector table exceeds address space");
   end

   logic               wr_req, wr_en_reg;
   logic [NUM_SRC-1:0] req_q;
   logic [DATA_W-1:0]  en_q;
   logic               ime_q;
   logic [NUM_SRC-1:0] eligible;
   logic [NUM_SRC-1:0] grant;
   logic [IDX_W-1:0]   pick_idx;
   logic               pick_any;
   logic               take;

   assign wr_req    = bus_wr && (bus_addr == REQ_A);
   assign wr_en_reg = bus_wr && (bus_addr == EN_A);

   // Enable register keeps the full data width.
   always_ff @(posedge clk) begin
      if (!rst_n)         en_q <= '0;
      else if (wr_en_reg) en_q <= bus_wdata;
   end

   assign eligible = req_q & en_q[NUM_SRC-1:0] & {NUM_SRC{ime_q}};

   idu_prio_pick #(.N(NUM_SRC)) u_pick (
      .cand  (eligible),
      .grant (grant),
      .idx   (pick_idx),
      .any   (pick_any)
   );

   assign take            = insn_boundary & pick_any;
   assign dispatch_valid  = take;
   assign dispatch_vector = ADDR_W'(idu_pkg::vec_addr(VEC_BASE, VEC_STRIDE,
                                                      int'(pick_idx)));

   idu_req_reg #(.N(NUM_SRC)) u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_req),
      .wr_bits  (bus_wdata[NUM_SRC-1:0]),
      .clr_bits (grant & {NUM_SRC{take}}),
      .set_bits (src_pulse),
      .q        (req_q)
   );

   idu_master_en u_ime (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (dec_ei | dec_reti),
      .clr_req (dec_di),
      .take    (take),
      .q       (ime_q)
   );

   assign ime = ime_q;

   // Read mux: unused request positions read as ones.
   logic [DATA_W-1:0] rd_req;
   always_comb begin
      rd_req              = '1;
      rd_req[NUM_SRC-1:0] = req_q;
      if (bus_addr == REQ_A)     bus_rdata = rd_req;
      else if (bus_addr == EN_A) bus_rdata = en_q;
      else                       bus_rdata = '0;
   end
endmodule

// File: rtl/idu_dispatch_chk.sv
module idu_dispatch_chk #(
   parameter int NUM_SRC    = 5,
   parameter int ADDR_W     = 16,
   parameter int VEC_BASE   = 'h40,
   parameter int VEC_STRIDE = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_pulse,
   input logic               dec_di,
   input logic               dec_ei,
   input logic               dec_reti,
   input logic               insn_boundary,
   input logic               dispatch_valid,
   input logic [ADDR_W-1:0]  dispatch_vector,
   input logic               ime,
   input logic [NUM_SRC-1:0] req_q
);
   localparam logic [ADDR_W-1:0] V_LO = ADDR_W'(VEC_BASE);
   localparam logic [ADDR_W-1:0] V_HI = ADDR_W'(VEC_BASE + VEC_STRIDE * (NUM_SRC - 1));

   assert_gate_ime_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ime |-> !dispatch_valid);

   assert_gate_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_boundary |-> !dispatch_valid);

   assert_vector_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dispatch_valid |-> (dispatch_vector >= V_LO && dispatch_vector <= V_HI));

   assert_take_drops_ime_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dispatch_valid |=> !ime);

   assert_di_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dec_di |=> !ime);

   assert_ei_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((dec_ei || dec_reti) && !dec_di && !dispatch_valid) |=> ime);

   assert_pulse_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (src_pulse != '0) |=> ((req_q & $past(src_pulse)) == $past(src_pulse)));
endmodule

bind idu_dispatch idu_dispatch_chk #(
   .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .src_pulse       (src_pulse),
   .dec_di          (dec_di),
   .dec_ei          (dec_ei),
   .dec_reti        (dec_reti),
   .insn_boundary   (insn_boundary),
   .dispatch_valid  (dispatch_valid),
   .dispatch_vector (dispatch_vector),
   .ime             (ime),
   .req_q           (req_q)
);

// File: tb/tb_idu_dispatch.sv
module tb_idu_dispatch;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = 16'h0000;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = 8'h00;
   logic [7:0]  bus_rdata;
   logic [4:0]  src_pulse = '0;
   logic        dec_di = 1'b0, dec_ei = 1'b0, dec_reti = 1'b0;
   logic        insn_boundary = 1'b0;
   logic        dispatch_valid;
   logic [15:0] dispatch_vector;
   logic        ime;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   idu_dispatch dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_pulse(src_pulse),
      .dec_di(dec_di), .dec_ei(dec_ei), .dec_reti(dec_reti),
      .insn_boundary(insn_boundary), .dispatch_valid(dispatch_valid),
      .dispatch_vector(dispatch_vector), .ime(ime)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // All tasks start and end just after a falling edge.
   task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic read_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
      bus_addr = a;
      #1;
      chk(tag, {8'h00, bus_rdata}, {8'h00, exp});
   endtask

   task automatic strobe(input logic di, input logic ei, input logic reti);
      dec_di = di; dec_ei = ei; dec_reti = reti;
      @(negedge clk);
      dec_di = 1'b0; dec_ei = 1'b0; dec_reti = 1'b0;
   endtask

   // {request, enable, expected valid, expected vector}
   localparam logic [32:0] TBL [8] = '{
      {8'h1F, 8'h1F, 1'b1, 16'h0040},
      {8'h1E, 8'h1F, 1'b1, 16'h0048},
      {8'h1C, 8'h1F, 1'b1, 16'h0050},
      {8'h18, 8'h1F, 1'b1, 16'h0058},
      {8'h10, 8'h1F, 1'b1, 16'h0060},
      {8'h1F, 8'h00, 1'b0, 16'h0000},
      {8'h0A, 8'h0C, 1'b1, 16'h0058},
      {8'h00, 8'h1F, 1'b0, 16'h0000}
   };

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      read_chk("R1 req after reset", 16'hFF0F, 8'hE0);
      read_chk("R1 en after reset", 16'hFFFF, 8'h00);
      chk("R1 ime after reset", {15'd0, ime}, 16'd0);
      insn_boundary = 1'b1; #1;
      chk("R1 no dispatch after reset", {15'd0, dispatch_valid}, 16'd0);
      insn_boundary = 1'b0;

      // R6/R7 table of priority cases
      for (int k = 0; k < 8; k++) begin
         logic [32:0] e;
         e = TBL[k];
         bus_write(16'hFF0F, e[32:25]);
         bus_write(16'hFFFF, e[24:17]);
         strobe(1'b0, 1'b1, 1'b0);
         #1;
         chk("R6 no dispatch off boundary", {15'd0, dispatch_valid}, 16'd0);
         insn_boundary = 1'b1; #1;
         chk("R6 dispatch valid", {15'd0, dispatch_valid}, {15'd0, e[16]});
         if (e[16]) chk("R7 vector", dispatch_vector, e[15:0]);
         insn_boundary = 1'b0;
         @(negedge clk);
      end

      // R2 upper bits read as one; R3 full enable readback
      bus_write(16'hFF0F, 8'h15);
      read_chk("R2 req readback", 16'hFF0F, 8'hF5);
      bus_write(16'hFFFF, 8'hA7);
      read_chk("R3 en readback", 16'hFFFF, 8'hA7);

      // R4 pulse sets and sticks
      bus_write(16'hFF0F, 8'h00);
      src_pulse = 5'b00010; @(negedge clk); src_pulse = '0;
      repeat (3) @(negedge clk);
      read_chk("R4 pulse sticks", 16'hFF0F, 8'hE2);

      // R5 pulse beats same-cycle write
      src_pulse = 5'b00100;
      bus_write(16'hFF0F, 8'h00);
      src_pulse = '0;
      read_chk("R5 pulse over write zero", 16'hFF0F, 8'hE4);
      src_pulse = 5'b01000;
      bus_write(16'hFF0F, 8'h01);
      src_pulse = '0;
      read_chk("R5 pulse merges with write", 16'hFF0F, 8'hE9);

      // R8 dispatch clears only winner and master enable
      bus_write(16'hFF0F, 8'h03);
      bus_write(16'hFFFF, 8'h03);
      strobe(1'b0, 1'b1, 1'b0);
      insn_boundary = 1'b1; #1;
      chk("R8 first vector", dispatch_vector, 16'h0040);
      @(negedge clk);
      insn_boundary = 1'b0;
      read_chk("R8 winner cleared", 16'hFF0F, 8'hE2);
      chk("R8 ime cleared", {15'd0, ime}, 16'd0);
      insn_boundary = 1'b1; #1;
      chk("R6 blocked by ime", {15'd0, dispatch_valid}, 16'd0);
      insn_boundary = 1'b0;
      strobe(1'b0, 1'b0, 1'b1);
      chk("R9 reti sets ime", {15'd0, ime}, 16'd1);
      insn_boundary = 1'b1; #1;
      chk("R8 second vector", dispatch_vector, 16'h0048);
      @(negedge clk);
      insn_boundary = 1'b0;
      read_chk("R8 second cleared", 16'hFF0F, 8'hE0);

      // R9 strobes
      strobe(1'b0, 1'b1, 1'b0);
      chk("R9 ei sets", {15'd0, ime}, 16'd1);
      strobe(1'b1, 1'b0, 1'b0);
      chk("R9 di clears", {15'd0, ime}, 16'd0);
      strobe(1'b0, 1'b1, 1'b0);
      strobe(1'b1, 1'b1, 1'b0);
      chk("R9 di overrides ei", {15'd0, ime}, 16'd0);
      bus_write(16'hFF0F, 8'h10);
      bus_write(16'hFFFF, 8'h10);
      strobe(1'b0, 1'b1, 1'b0);
      dec_ei = 1'b1; insn_boundary = 1'b1; #1;
      chk("R9 dispatch with ei", dispatch_vector, 16'h0060);
      @(negedge clk);
      dec_ei = 1'b0; insn_boundary = 1'b0;
      chk("R9 dispatch beats ei", {15'd0, ime}, 16'd0);

      // R10 foreign addresses
      bus_write(16'hFF0F, 8'h05);
      bus_write(16'hFFFF, 8'h0F);
      bus_write(16'hFF0E, 8'hFF);
      bus_write(16'hFFFE, 8'h00);
      read_chk("R10 req untouched", 16'hFF0F, 8'hE5);
      read_chk("R10 en untouched", 16'hFFFF, 8'h0F);
      read_chk("R10 other reads zero", 16'hC000, 8'h00);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule